// File: doc/BRIEF.md
# Lowest-Priority Interrupt Bus Arbiter

This block settles contention when several interrupt controller agents want a shared message bus in the same cycle. Each agent offers a request bit, a flag that marks its message as an end-of-interrupt, an 8-bit current processor priority and a unique 4-bit arbitration ID. The arbiter picks one winner per cycle, registers the decision, and presents it one clock later as a one-hot grant vector, a binary winner index and a valid flag.

Selection runs in two levels. End-of-interrupt traffic pre-empts everything else. When more than one end-of-interrupt sender competes, the one with the highest arbitration ID wins. With no end-of-interrupt pending, the requester with the numerically lowest processor priority wins, and the full 8-bit value is compared. Ties on priority go to the highest arbitration ID. Agents that do not request take no part, whatever the values on their other inputs.

Top module: `lpa_bus_arbiter`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, grant_o is all zeros, winner_o is 0 and valid_o is 0.
- R2: If no req_i bit is set in a sampled cycle, the next cycle shows valid_o = 0, grant_o = 0 and winner_o = 0.
- R3: The outputs change only on a clock edge. The decision for the inputs sampled at one rising edge appears after that edge and holds until the next one.
- R4: Whenever at least one agent requests, the next cycle shows valid_o = 1 and exactly one grant_o bit set. winner_o holds that bit's index, where bit i of grant_o is agent i.
- R5: If exactly one requesting agent has its eoi_i bit at 1, that agent is granted, whatever its priority or ID.
- R6: If two or more requesting agents have eoi_i at 1, the one with the highest arbitration ID is granted, and processor priority is ignored.
- R7: With no requesting end-of-interrupt sender, the requester with the numerically lowest 8-bit prio_i value is granted. Agent i's priority is prio_i[8*i+7:8*i], and values that differ only in bit 0 are told apart.
- R8: Among requesters that tie on the lowest priority, the one with the highest arbitration ID is granted. Agent i's ID is id_i[4*i+3:4*i].
- R9: An agent with req_i low is never granted. Its eoi_i, prio_i and id_i values do not change which agent wins.
- R10: The arbitration IDs of the agents requesting in one cycle are all distinct. The environment must keep to this, and the checker flags any violation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | N_AGENTS | Per-agent bus request |
| eoi_i | input | N_AGENTS | Per-agent flag: message is an end-of-interrupt |
| prio_i | input | N_AGENTS*PRIO_W | Packed current processor priorities, agent i at bits [PRIO_W*i +: PRIO_W] |
| id_i | input | N_AGENTS*ID_W | Packed arbitration IDs, agent i at bits [ID_W*i +: ID_W] |
| grant_o | output | N_AGENTS | Registered one-hot grant |
| winner_o | output | IDX_W | Registered index of the granted agent |
| valid_o | output | 1 | Registered flag: a winner exists |

## Verification
Some properties are checked on every cycle:
- The grant is one-hot.
- The valid flag, the index and the grant agree with one another.
- Idle cycles produce no grant, and busy cycles always produce one.
- A grant goes only to an agent that requested in the previous cycle.
- A pending end-of-interrupt always beats ordinary traffic.
- With no end-of-interrupt pending, no requester with a strictly lower priority is passed over.
- Requesting agents never share an ID.

The bench scenarios are needed to show which agent wins a tie:
- the highest-ID rule among several end-of-interrupt senders and among equal priorities;
- a winner decided by the least significant priority bit alone;
- the inputs of idle agents being ignored.

// File: rtl/lpa_pkg.sv
package lpa_pkg;

    // Message class carried by the per-agent flag
    typedef enum logic {
        MSG_ORDINARY = 1'b0,
        MSG_EOI      = 1'b1
    } msg_kind_e;

    // Width of an index that addresses n items (at least one bit)
    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/lpa_key_build.sv
// Turns each agent's inputs into a single ordering key. A larger key wins.
// Key layout, MSB first: {eoi, inverted priority (zero for eoi), id}
module lpa_key_build #(
    parameter int N_AGENTS = 4,
    parameter int PRIO_W   = 8,
    parameter int ID_W     = 4,
    localparam int KEY_W   = 1 + PRIO_W + ID_W
) (
    input  logic [N_AGENTS-1:0]        req,
    input  logic [N_AGENTS-1:0]        eoi,
    input  logic [N_AGENTS*PRIO_W-1:0] prio,
    input  logic [N_AGENTS*ID_W-1:0]   ids,
    output logic [N_AGENTS-1:0]        cand_vld,
    output logic [N_AGENTS*KEY_W-1:0]  cand_key
);
    import lpa_pkg::*;

    for (genvar a = 0; a < N_AGENTS; a++) begin : g_agent
        msg_kind_e           kind;
        logic [PRIO_W-1:0]   prio_field;

        assign kind       = msg_kind_e'(eoi[a]);
        // End-of-interrupt senders compete on ID alone
        assign prio_field = (kind == MSG_EOI) ? '0 : ~prio[a*PRIO_W +: PRIO_W];
        assign cand_vld[a] = req[a];
        assign cand_key[a*KEY_W +: KEY_W] = {(kind == MSG_EOI), prio_field, ids[a*ID_W +: ID_W]};
    end

endmodule

// File: rtl/lpa_select_tree.sv
// Balanced max-key reduction tree over N candidates
module lpa_select_tree #(
    parameter int N_AGENTS = 4,
    parameter int KEY_W    = 13,
    localparam int IDX_W   = lpa_pkg::idx_width(N_AGENTS),
    localparam int DEPTH   = IDX_W,
    localparam int LEAVES  = 1 << DEPTH
) (
    input  logic [N_AGENTS-1:0]       cand_vld,
    input  logic [N_AGENTS*KEY_W-1:0] cand_key,
    output logic                      win_vld,
    output logic [IDX_W-1:0]          win_idx
);

    for (genvar lv = 0; lv <= DEPTH; lv++) begin : g_lvl
        localparam int W = LEAVES >> lv;
        logic             v [W];
        logic [KEY_W-1:0] k [W];
        logic [IDX_W-1:0] x [W];

        if (lv == 0) begin : g_leaf
            for (genvar l = 0; l < W; l++) begin : g_l
                if (l < N_AGENTS) begin : g_real
                    assign v[l] = cand_vld[l];
                    assign k[l] = cand_key[l*KEY_W +: KEY_W];
                    assign x[l] = IDX_W'(l);
                end else begin : g_pad
                    assign v[l] = 1'b0;
                    assign k[l] = '0;
                    assign x[l] = '0;
                end
            end
        end else begin : g_node
            for (genvar n = 0; n < W; n++) begin : g_n
                logic take_left;
                assign take_left = g_lvl[lv-1].v[2*n] &&
                                   (!g_lvl[lv-1].v[2*n+1] ||
                                    (g_lvl[lv-1].k[2*n] >= g_lvl[lv-1].k[2*n+1]));
                assign v[n] = g_lvl[lv-1].v[2*n] | g_lvl[lv-1].v[2*n+1];
                assign k[n] = take_left ? g_lvl[lv-1].k[2*n] : g_lvl[lv-1].k[2*n+1];
                assign x[n] = take_left ? g_lvl[lv-1].x[2*n] : g_lvl[lv-1].x[2*n+1];
            end
        end
    end

    assign win_vld = g_lvl[DEPTH].v[0];
    assign win_idx = g_lvl[DEPTH].x[0];

endmodule

// File: rtl/lpa_bus_arbiter.sv
module lpa_bus_arbiter #(
    parameter int N_AGENTS = 4,
    parameter int PRIO_W   = 8,
    parameter int ID_W     = 4,
    localparam int IDX_W   = lpa_pkg::idx_width(N_AGENTS),
    localparam int KEY_W   = 1 + PRIO_W + ID_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [N_AGENTS-1:0]        req_i,
    input  logic [N_AGENTS-1:0]        eoi_i,
    input  logic [N_AGENTS*PRIO_W-1:0] prio_i,
    input  logic [N_AGENTS*ID_W-1:0]   id_i,
    output logic [N_AGENTS-1:0]        grant_o,
    output logic [IDX_W-1:0]           winner_o,
    output logic                       valid_o
);

    typedef struct packed {
        logic [N_AGENTS-1:0] grant;
        logic [IDX_W-1:0]    winner;
        logic                valid;
    } arb_state_t;

    arb_state_t             st_d, st_q;
    logic [N_AGENTS-1:0]    cand_vld;
    logic [N_AGENTS*KEY_W-1:0] cand_key;
    logic                   win_vld;
    logic [IDX_W-1:0]       win_idx;

    lpa_key_build #(
        .N_AGENTS (N_AGENTS),
        .PRIO_W   (PRIO_W),
        .ID_W     (ID_W)
    ) u_keys (
        .req      (req_i),
        .eoi      (eoi_i),
        .prio     (prio_i),
        .ids      (id_i),
        .cand_vld (cand_vld),
        .cand_key (cand_key)
    );

    lpa_select_tree #(
        .N_AGENTS (N_AGENTS),
        .KEY_W    (KEY_W)
    ) u_tree (
        .cand_vld (cand_vld),
        .cand_key (cand_key),
        .win_vld  (win_vld),
        .win_idx  (win_idx)
    );

    always_comb begin
        st_d = '0;
        if (win_vld) begin
            st_d.valid          = 1'b1;
            st_d.winner         = win_idx;
            st_d.grant[win_idx] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign grant_o  = st_q.grant;
    assign winner_o = st_q.winner;
    assign valid_o  = st_q.valid;

endmodule

// File: rtl/lpa_arb_checker.sv
module lpa_arb_checker #(
    parameter int N_AGENTS = 4,
    parameter int PRIO_W   = 8,
    parameter int ID_W     = 4,
    localparam int IDX_W   = lpa_pkg::idx_width(N_AGENTS)
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [N_AGENTS-1:0]        req_i,
    input logic [N_AGENTS-1:0]        eoi_i,
    input logic [N_AGENTS*PRIO_W-1:0] prio_i,
    input logic [N_AGENTS*ID_W-1:0]   id_i,
    input logic [N_AGENTS-1:0]        grant_o,
    input logic [IDX_W-1:0]           winner_o,
    input logic                       valid_o
);

    p_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o));

    p_valid_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o == (grant_o != '0));

    p_index_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> grant_o[winner_o]);

    p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i == '0) |=> !valid_o);

    p_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i != '0) |=> valid_o);

    for (genvar j = 0; j < N_AGENTS; j++) begin : g_j
        p_only_requester_r9: assert property (@(posedge clk) disable iff (!rst_n)
            grant_o[j] |-> $past(req_i[j]));

        p_eoi_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (grant_o[j] && $past((req_i & eoi_i) != '0)) |-> $past(eoi_i[j]));

        for (genvar k = 0; k < N_AGENTS; k++) begin : g_k
            if (k != j) begin : g_pair
                p_lowest_prio_r7: assert property (@(posedge clk) disable iff (!rst_n)
                    (grant_o[j] && $past(req_i[k]) && $past((req_i & eoi_i) == '0))
                    |-> ($past(prio_i[j*PRIO_W +: PRIO_W]) <= $past(prio_i[k*PRIO_W +: PRIO_W])));
            end
            if (k > j) begin : g_uniq
                p_unique_id_r10: assert property (@(posedge clk) disable iff (!rst_n)
                    (req_i[j] && req_i[k]) |-> (id_i[j*ID_W +: ID_W] != id_i[k*ID_W +: ID_W]));
            end
        end
    end

endmodule

bind lpa_bus_arbiter lpa_arb_checker #(
    .N_AGENTS (N_AGENTS),
    .PRIO_W   (PRIO_W),
    .ID_W     (ID_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_i    (req_i),
    .eoi_i    (eoi_i),
    .prio_i   (prio_i),
    .id_i     (id_i),
    .grant_o  (grant_o),
    .winner_o (winner_o),
    .valid_o  (valid_o)
);

// File: tb/test_lpa_bus_arbiter.sv
`timescale 1ns/1ps
module test_lpa_bus_arbiter;
    localparam int N  = 4;
    localparam int PW = 8;
    localparam int IW = 4;
    localparam int XW = 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N-1:0]    req = '0;
    logic [N-1:0]    eoi = '0;
    logic [N*PW-1:0] prio = '0;
    logic [N*IW-1:0] ids = '0;
    logic [N-1:0]    grant;
    logic [XW-1:0]   winner;
    logic            valid;

    int total = 0;
    int bad = 0;
    logic [N-1:0]  pg = '0;
    logic [XW-1:0] pw = '0;
    logic          pv = 1'b0;

    always #5 clk = ~clk;

    lpa_bus_arbiter #(.N_AGENTS(N), .PRIO_W(PW), .ID_W(IW)) i_lpa_bus_arbiter (
        .clk(clk), .rst_n(rst_n), .req_i(req), .eoi_i(eoi), .prio_i(prio), .id_i(ids),
        .grant_o(grant), .winner_o(winner), .valid_o(valid)
    );

    // Behavioural reference: returns the winning agent, or -1 if none
    function automatic int ref_pick(input logic [N-1:0] r, input logic [N-1:0] e,
                                    input logic [N*PW-1:0] p, input logic [N*IW-1:0] d);
        int best = -1;
        bit any_eoi = 0;
        for (int a = 0; a < N; a++) if (r[a] && e[a]) any_eoi = 1;
        for (int a = 0; a < N; a++) begin
            if (!r[a]) continue;
            if (any_eoi && !e[a]) continue;
            if (best < 0) best = a;
            else if (any_eoi) begin
                if (int'(d[a*IW +: IW]) > int'(d[best*IW +: IW])) best = a;
            end else begin
                if (int'(p[a*PW +: PW]) < int'(p[best*PW +: PW])) best = a;
                else if (p[a*PW +: PW] == p[best*PW +: PW] &&
                         int'(d[a*IW +: IW]) > int'(d[best*IW +: IW])) best = a;
            end
        end
        return best;
    endfunction

    task automatic check(input string tag, input logic [N-1:0] eg,
                         input logic [XW-1:0] ew, input logic ev);
        total++;
        if (grant !== eg || winner !== ew || valid !== ev) begin
            bad++;
            $display("FAIL %s: grant=%b winner=%0d valid=%b expected grant=%b winner=%0d valid=%b",
                     tag, grant, winner, valid, eg, ew, ev);
        end
    endtask

    // Called just after a falling edge: drive, confirm outputs still hold, check after next edge
    task automatic apply(input string tag, input logic [N-1:0] r, input logic [N-1:0] e,
                         input logic [N*PW-1:0] p, input logic [N*IW-1:0] d);
        int w;
        req = r; eoi = e; prio = p; ids = d;
        w = ref_pick(r, e, p, d);
        #1;
        check({tag, " R3 hold"}, pg, pw, pv);
        @(negedge clk);
        pg = '0; pw = '0; pv = 1'b0;
        if (w >= 0) begin
            pg[w] = 1'b1; pw = XW'(w); pv = 1'b1;
        end
        check(tag, pg, pw, pv);
    endtask

    function automatic logic [N*PW-1:0] pk_p(input int a0, input int a1, input int a2, input int a3);
        return {PW'(a3), PW'(a2), PW'(a1), PW'(a0)};
    endfunction

    function automatic logic [N*IW-1:0] pk_d(input int a0, input int a1, input int a2, input int a3);
        return {IW'(a3), IW'(a2), IW'(a1), IW'(a0)};
    endfunction

    initial begin
        #(200000 * 10);
        total++; bad++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int pool[16];
        logic [N-1:0] r, e;
        logic [N*PW-1:0] p;
        logic [N*IW-1:0] d;

        @(negedge clk);
        @(negedge clk);
        check("R1 in reset", '0, '0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", '0, '0, 1'b0);

        apply("R2 idle", 4'b0000, 4'b1111, pk_p(0, 0, 0, 0), pk_d(1, 2, 3, 4));
        apply("R4 single requester", 4'b0100, 4'b0000, pk_p(0, 0, 8'hFF, 0), pk_d(5, 6, 1, 7));
        apply("R2 idle again", 4'b0000, 4'b0000, pk_p(0, 0, 0, 0), pk_d(1, 2, 3, 4));
        apply("R5 single eoi", 4'b1111, 4'b0010, pk_p(1, 8'hFF, 2, 3), pk_d(9, 0, 14, 15));
        apply("R6 multi eoi", 4'b1111, 4'b1001, pk_p(8'h10, 0, 0, 8'hF0), pk_d(2, 12, 13, 9));
        apply("R6 all eoi", 4'b1111, 4'b1111, pk_p(0, 1, 2, 3), pk_d(4, 11, 3, 10));
        apply("R7 lsb only", 4'b1111, 4'b0000, pk_p(8'h81, 8'h80, 8'h90, 8'hFF), pk_d(15, 0, 14, 13));
        apply("R7 msb", 4'b1011, 4'b0000, pk_p(8'h80, 8'h7F, 8'h00, 8'hFE), pk_d(1, 2, 3, 4));
        apply("R8 all equal", 4'b1111, 4'b0000, pk_p(7, 7, 7, 7), pk_d(3, 8, 12, 5));
        apply("R8 partial tie", 4'b1111, 4'b0000, pk_p(4, 9, 4, 4), pk_d(6, 15, 2, 1));
        apply("R9 idle eoi ignored", 4'b0110, 4'b1001, pk_p(0, 5, 3, 0), pk_d(15, 1, 2, 14));
        apply("R9 idle low prio ignored", 4'b1010, 4'b0000, pk_p(8'h50, 8'h60, 0, 8'h70), pk_d(1, 2, 15, 3));
        apply("R2 back to idle", 4'b0000, 4'b0000, pk_p(0, 0, 0, 0), pk_d(0, 0, 0, 0));

        for (int t = 0; t < 600; t++) begin
            for (int i = 0; i < 16; i++) pool[i] = i;
            for (int i = 15; i > 0; i--) begin
                int j, tmp;
                j = $urandom_range(0, i);
                tmp = pool[i]; pool[i] = pool[j]; pool[j] = tmp;
            end
            for (int a = 0; a < N; a++) begin
                r[a] = ($urandom_range(0, 3) != 0);
                e[a] = ($urandom_range(0, 4) == 0);
                p[a*PW +: PW] = (t % 2 == 0) ? PW'($urandom_range(0, 3)) : PW'($urandom);
                d[a*IW +: IW] = IW'(pool[a]);
            end
            apply("R7 R8 R6 random", r, e, p, d);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule